// File: doc/BRIEF.md
# Sound-Level Sensor Register Bank

This block is the byte-wide register bank of a sound-level sensor. A host reaches it through a simple register port (address, write data, write strobe, read strobe, read data) that a bus slave drives. The bank keeps the writable settings: a scratch byte, a control byte and a two-byte averaging period. It presents those settings as control outputs and turns writes to a write-only command register into one-cycle command pulses.

Reads of the live reading, the observed minimum and maximum, the two alarm thresholds and the history entries go through the bank to sources outside it. For the history window the bank also produces the entry index. The averaging period is staged. The host writes the high byte first, and the pair takes effect only when the low byte is written. The period in use is held within its supported range. Power-down latches: a write can set it but cannot clear it, and only a system-reset command clears it.

Top module: `sensor_regfile`

## Requirements
- R1: After rst_n is released the control outputs are int_mode_o=0, int_en_o=0, weight_o=01 and pwrdn_o=0, period_o is 1000, the scratch byte reads 0x00 and no command pulse is active.
- R2: A read strobe at a clock edge loads reg_rdata with the addressed byte, visible from that edge, and reg_rdata holds until the next read strobe. Address 0x00 always reads 0x31.
- R3: Addresses 0x01, 0x02, 0x03 and 0x04 read dev_id_i[31:24], [23:16], [15:8] and [7:0] respectively, and writes to them have no effect.
- R4: Address 0x05 stores any written byte and returns it on read.
- R5: The control byte at 0x06 maps bit 4 to int_mode_o, bit 3 to int_en_o, bits [2:1] to weight_o (00 Z, 01 A, 10 C, 11 reserved) and bit 0 to pwrdn_o. Bits [7:5] are stored as 0. It resets to 0x02.
- R6: Writing 0 to control bit 0 leaves pwrdn_o at 1. Only a system-reset command returns it to 0.
- R7: Address 0x07 holds the period high byte (reset 0x03) and 0x08 the low byte (reset 0xE8), and both read back as written. period_o changes only when 0x08 is written, and then takes the value 256*high + written low.
- R8: A committed period below 10 drives period_o to 10, and one above 10000 drives it to 10000.
- R9: A write to 0x09 produces, in the cycle after the write edge only, cmd_int_clr_o from bit 0, cmd_mm_clr_o from bit 1, cmd_hist_clr_o from bit 2 and cmd_sys_rst_o from bit 3. Bits [7:4] cause nothing, and 0x09 reads 0x00.
- R10: A system-reset command restores the control, period (high, low and committed) and scratch registers to their reset values at its write edge.
- R11: Addresses 0x0A, 0x0B, 0x0C, 0x0D and 0x0E read level_i, min_i, max_i, thr_lo_i and thr_hi_i. For addresses 0x14 to 0x77, hist_idx_o equals address minus 0x14 and the read returns hist_data_i.
- R12: All other addresses read 0x00, and writes to any read-only or unmapped address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| dev_id_i | input | 32 | Per-device identifier |
| level_i | input | 8 | Live sound level |
| min_i | input | 8 | Observed minimum |
| max_i | input | 8 | Observed maximum |
| thr_lo_i | input | 8 | Lower alarm threshold |
| thr_hi_i | input | 8 | Upper alarm threshold |
| hist_idx_o | output | 7 | History entry index for the current address |
| hist_data_i | input | 8 | History entry value |
| int_mode_o | output | 1 | Interrupt mode select |
| int_en_o | output | 1 | Interrupt enable |
| weight_o | output | 2 | Frequency weighting select |
| pwrdn_o | output | 1 | Power-down |
| period_o | output | 16 | Clamped averaging period in ms |
| cmd_int_clr_o | output | 1 | Clear-interrupt pulse |
| cmd_mm_clr_o | output | 1 | Clear-min/max pulse |
| cmd_hist_clr_o | output | 1 | Clear-history pulse |
| cmd_sys_rst_o | output | 1 | System-reset pulse |

## Verification
The read path is swept over all 256 addresses three times: in the reset state, after 0xFF has been written to every address except the command register, and after a system reset. The first sweep separates each mapped source from its neighbours and from the unmapped gaps. The second separates the writable bytes from the read-only ones and exposes reserved bits that were stored. The scratch byte is written and read back with every value.

The period is driven through values below, at and above both limits, including 0 and 65535. A high-byte write alone is checked to leave period_o unchanged, which separates staging from immediate update. Command writes set single bits, set only the reserved bits, and set the system-reset bit. These show pulse width, bit mapping and the restore of defaults. A zero written to the control byte confirms that power-down is sticky.

// File: rtl/srf_pkg.sv
package srf_pkg;

   localparam int A_VERSION  = 'h00;
   localparam int A_ID_FIRST = 'h01;
   localparam int ID_BYTES   = 4;
   localparam int A_SCRATCH  = 'h05;
   localparam int A_CTRL     = 'h06;
   localparam int A_PER_HI   = 'h07;
   localparam int A_PER_LO   = 'h08;
   localparam int A_CMD      = 'h09;
   localparam int A_LEVEL    = 'h0A;
   localparam int A_MIN      = 'h0B;
   localparam int A_MAX      = 'h0C;
   localparam int A_THR_LO   = 'h0D;
   localparam int A_THR_HI   = 'h0E;

   typedef struct packed {
      logic       int_mode;
      logic       int_en;
      logic [1:0] weight;
      logic       pwrdn;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{int_mode: 1'b0, int_en: 1'b0, weight: 2'b01, pwrdn: 1'b0};

   localparam int NCMD = 4;

   typedef struct packed {
      logic sys_rst;
      logic hist_clr;
      logic mm_clr;
      logic int_clr;
   } cmd_t;

endpackage

// File: rtl/srf_ctrl_reg.sv
module srf_ctrl_reg
   import srf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       wr_en,
   input  logic [4:0] wbits,
   output ctrl_t      ctrl_q,
   output logic [7:0] rd_byte
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (soft_rst) begin
         ctrl_q <= CTRL_RST;
      end else if (wr_en) begin
         ctrl_q.int_mode <= wbits[4];
         ctrl_q.int_en   <= wbits[3];
         ctrl_q.weight   <= wbits[2:1];
         ctrl_q.pwrdn    <= ctrl_q.pwrdn | wbits[0];
      end
   end

   assign rd_byte = {3'b000, ctrl_q};

   // Power-down may only drop on a system-reset command
   assert_pwrdn_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q.pwrdn) |-> $past(soft_rst));

endmodule

// File: rtl/srf_period_stage.sv
module srf_period_stage #(
   parameter int PW       = 16,
   parameter int PMIN     = 10,
   parameter int PMAX     = 10000,
   parameter int PRST     = 1000,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          hi_wr,
   input  logic          lo_wr,
   input  logic [7:0]    wdata,
   output logic [7:0]    hi_byte,
   output logic [7:0]    lo_byte,
   output logic [PW-1:0] period_o
);

   localparam logic [PW-1:0] RST_V = PW'(PRST);
   localparam logic [PW-1:0] MIN_V = PW'(PMIN);
   localparam logic [PW-1:0] MAX_V = PW'(PMAX);

   if (PW != 16) begin : g_bad_pw
      $error("period width must be two bytes");
   end
   if (PMIN > PMAX || PRST < PMIN || PRST > PMAX) begin : g_bad_lim
      $error("period limits inconsistent");
   end

   logic [7:0]    hi_q, lo_q;
   logic [PW-1:0] commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= RST_V[15:8];
         lo_q     <= RST_V[7:0];
         commit_q <= RST_V;
      end else if (soft_rst) begin
         hi_q     <= RST_V[15:8];
         lo_q     <= RST_V[7:0];
         commit_q <= RST_V;
      end else begin
         if (hi_wr) hi_q <= wdata;
         if (lo_wr) begin
            lo_q     <= wdata;
            commit_q <= {hi_q, wdata};
         end
      end
   end

   assign hi_byte = hi_q;
   assign lo_byte = lo_q;

   if (CLAMP_EN) begin : g_clamp
      always_comb begin
         if (commit_q < MIN_V)      period_o = MIN_V;
         else if (commit_q > MAX_V) period_o = MAX_V;
         else                       period_o = commit_q;
      end
      assert_period_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (period_o >= MIN_V) && (period_o <= MAX_V));
   end else begin : g_pass
      assign period_o = commit_q;
   end

   // The period in use moves only after a low-byte write or a system reset
   assert_period_staged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_wr && !soft_rst) |=> $stable(period_o));

endmodule

// File: rtl/srf_cmd_reg.sv
module srf_cmd_reg
   import srf_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit,
   input  logic [NCMD-1:0] wbits,
   output cmd_t            pulse_q
);

   logic [NCMD-1:0] p_q;

   for (genvar i = 0; i < NCMD; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q[i] <= 1'b0;
         else        p_q[i] <= hit & wbits[i];
      end
      // A pulse exists only in the cycle after a matching command write
      assert_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
         p_q[i] |-> $past(hit && wbits[i]));
   end

   assign pulse_q = cmd_t'(p_q);

endmodule

// File: rtl/srf_read_mux.sv
module srf_read_mux
   import srf_pkg::*;
#(
   parameter int       ADDR_W     = 8,
   parameter int       HIST_BASE  = 'h14,
   parameter int       HIST_DEPTH = 100,
   parameter int       IDX_W      = 7,
   parameter bit [7:0] VERSION    = 8'h31
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       dev_id,
   input  logic [7:0]        scratch,
   input  logic [7:0]        ctrl_byte,
   input  logic [7:0]        per_hi,
   input  logic [7:0]        per_lo,
   input  logic [7:0]        level,
   input  logic [7:0]        min_v,
   input  logic [7:0]        max_v,
   input  logic [7:0]        thr_lo,
   input  logic [7:0]        thr_hi,
   input  logic [7:0]        hist_data,
   output logic [IDX_W-1:0]  hist_idx,
   output logic              mapped,
   output logic [7:0]        sel_byte
);

   logic in_hist;
   assign in_hist  = (int'(addr) >= HIST_BASE) && (int'(addr) < HIST_BASE + HIST_DEPTH);
   assign hist_idx = in_hist ? IDX_W'(int'(addr) - HIST_BASE) : '0;

   always_comb begin
      sel_byte = 8'h00;
      mapped   = 1'b1;
      case (int'(addr))
         A_VERSION: sel_byte = VERSION;
         A_SCRATCH: sel_byte = scratch;
         A_CTRL:    sel_byte = ctrl_byte;
         A_PER_HI:  sel_byte = per_hi;
         A_PER_LO:  sel_byte = per_lo;
         A_CMD:     sel_byte = 8'h00;
         A_LEVEL:   sel_byte = level;
         A_MIN:     sel_byte = min_v;
         A_MAX:     sel_byte = max_v;
         A_THR_LO:  sel_byte = thr_lo;
         A_THR_HI:  sel_byte = thr_hi;
         default:   mapped   = 1'b0;
      endcase
      for (int i = 0; i < ID_BYTES; i++) begin
         if (int'(addr) == A_ID_FIRST + i) begin
            sel_byte = dev_id[8*(ID_BYTES-1-i) +: 8];
            mapped   = 1'b1;
         end
      end
      if (in_hist) begin
         sel_byte = hist_data;
         mapped   = 1'b1;
      end
   end

endmodule

// File: rtl/sensor_regfile.sv
module sensor_regfile
   import srf_pkg::*;
#(
   parameter int       ADDR_W     = 8,
   parameter int       HIST_BASE  = 'h14,
   parameter int       HIST_DEPTH = 100,
   parameter int       PER_W      = 16,
   parameter int       PER_MIN    = 10,
   parameter int       PER_MAX    = 10000,
   parameter int       PER_RST    = 1000,
   parameter bit       CLAMP_EN   = 1'b1,
   parameter bit [7:0] VERSION    = 8'h31,
   localparam int      IDX_W      = $clog2(HIST_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [7:0]        reg_rdata,
   input  logic [31:0]       dev_id_i,
   input  logic [7:0]        level_i,
   input  logic [7:0]        min_i,
   input  logic [7:0]        max_i,
   input  logic [7:0]        thr_lo_i,
   input  logic [7:0]        thr_hi_i,
   output logic [IDX_W-1:0]  hist_idx_o,
   input  logic [7:0]        hist_data_i,
   output logic              int_mode_o,
   output logic              int_en_o,
   output logic [1:0]        weight_o,
   output logic              pwrdn_o,
   output logic [PER_W-1:0]  period_o,
   output logic              cmd_int_clr_o,
   output logic              cmd_mm_clr_o,
   output logic              cmd_hist_clr_o,
   output logic              cmd_sys_rst_o
);

   if (ADDR_W < 7) begin : g_bad_aw
      $error("address too narrow for history window");
   end
   if (HIST_BASE + HIST_DEPTH > (1 << ADDR_W)) begin : g_bad_hist
      $error("history window exceeds address space");
   end

   logic wr_scratch, wr_ctrl, wr_hi, wr_lo, wr_cmd, soft_rst;
   assign wr_scratch = reg_wr && (int'(reg_addr) == A_SCRATCH);
   assign wr_ctrl    = reg_wr && (int'(reg_addr) == A_CTRL);
   assign wr_hi      = reg_wr && (int'(reg_addr) == A_PER_HI);
   assign wr_lo      = reg_wr && (int'(reg_addr) == A_PER_LO);
   assign wr_cmd     = reg_wr && (int'(reg_addr) == A_CMD);
   assign soft_rst   = wr_cmd && reg_wdata[3];

   logic [7:0] scratch_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          scratch_q <= 8'h00;
      else if (soft_rst)   scratch_q <= 8'h00;
      else if (wr_scratch) scratch_q <= reg_wdata;
   end

   ctrl_t      ctrl;
   logic [7:0] ctrl_byte;
   srf_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (wr_ctrl),
      .wbits    (reg_wdata[4:0]),
      .ctrl_q   (ctrl),
      .rd_byte  (ctrl_byte)
   );

   logic [7:0] per_hi, per_lo;
   srf_period_stage #(
      .PW       (PER_W),
      .PMIN     (PER_MIN),
      .PMAX     (PER_MAX),
      .PRST     (PER_RST),
      .CLAMP_EN (CLAMP_EN)
   ) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .hi_wr    (wr_hi),
      .lo_wr    (wr_lo),
      .wdata    (reg_wdata),
      .hi_byte  (per_hi),
      .lo_byte  (per_lo),
      .period_o (period_o)
   );

   cmd_t cmd;
   srf_cmd_reg u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (wr_cmd),
      .wbits   (reg_wdata[NCMD-1:0]),
      .pulse_q (cmd)
   );

   logic [7:0] sel_byte;
   logic       mapped;
   srf_read_mux #(
      .ADDR_W     (ADDR_W),
      .HIST_BASE  (HIST_BASE),
      .HIST_DEPTH (HIST_DEPTH),
      .IDX_W      (IDX_W),
      .VERSION    (VERSION)
   ) u_mux (
      .addr      (reg_addr),
      .dev_id    (dev_id_i),
      .scratch   (scratch_q),
      .ctrl_byte (ctrl_byte),
      .per_hi    (per_hi),
      .per_lo    (per_lo),
      .level     (level_i),
      .min_v     (min_i),
      .max_v     (max_i),
      .thr_lo    (thr_lo_i),
      .thr_hi    (thr_hi_i),
      .hist_data (hist_data_i),
      .hist_idx  (hist_idx_o),
      .mapped    (mapped),
      .sel_byte  (sel_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= 8'h00;
      else if (reg_rd) reg_rdata <= sel_byte;
   end

   assign int_mode_o     = ctrl.int_mode;
   assign int_en_o       = ctrl.int_en;
   assign weight_o       = ctrl.weight;
   assign pwrdn_o        = ctrl.pwrdn;
   assign cmd_int_clr_o  = cmd.int_clr;
   assign cmd_mm_clr_o   = cmd.mm_clr;
   assign cmd_hist_clr_o = cmd.hist_clr;
   assign cmd_sys_rst_o  = cmd.sys_rst;

   assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !mapped) |=> (reg_rdata == 8'h00));

   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   assert_version_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && int'(reg_addr) == A_VERSION) |=> (reg_rdata == VERSION));

   assert_sysrst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!pwrdn_o && weight_o == 2'b01 && period_o == PER_W'(PER_RST)));

endmodule

// File: tb/sensor_regfile_tb_top.sv
`timescale 1ns/1ps
module sensor_regfile_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0, reg_wdata = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_rdata;
   logic [31:0] dev_id = 32'hC3A51E7B;
   logic [7:0]  level = 8'h3C, min_v = 8'h21, max_v = 8'h5A, thr_lo = 8'd45, thr_hi = 8'd85;
   logic [6:0]  hist_idx;
   logic [7:0]  hist_data;
   logic        int_mode, int_en, pwrdn;
   logic [1:0]  weight;
   logic [15:0] period;
   logic        p_int, p_mm, p_hist, p_sys;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0]  m_scratch, m_ctrl, m_hi, m_lo;
   logic [15:0] m_commit;

   always #5 clk = ~clk;

   assign hist_data = 8'(hist_idx * 3 + 7);

   sensor_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .dev_id_i(dev_id),
      .level_i(level), .min_i(min_v), .max_i(max_v), .thr_lo_i(thr_lo), .thr_hi_i(thr_hi),
      .hist_idx_o(hist_idx), .hist_data_i(hist_data), .int_mode_o(int_mode),
      .int_en_o(int_en), .weight_o(weight), .pwrdn_o(pwrdn), .period_o(period),
      .cmd_int_clr_o(p_int), .cmd_mm_clr_o(p_mm), .cmd_hist_clr_o(p_hist),
      .cmd_sys_rst_o(p_sys)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int clampv(input int v);
      if (v < 10) return 10;
      if (v > 10000) return 10000;
      return v;
   endfunction

   function automatic logic [7:0] exp_rd(input int a);
      if (a == 0) return 8'h31;
      if (a >= 1 && a <= 4) return dev_id[8*(4-a) +: 8];
      if (a == 5) return m_scratch;
      if (a == 6) return m_ctrl;
      if (a == 7) return m_hi;
      if (a == 8) return m_lo;
      if (a == 'h0A) return level;
      if (a == 'h0B) return min_v;
      if (a == 'h0C) return max_v;
      if (a == 'h0D) return thr_lo;
      if (a == 'h0E) return thr_hi;
      if (a >= 'h14 && a <= 'h77) return 8'((a - 'h14) * 3 + 7);
      return 8'h00;
   endfunction

   task automatic model_defaults();
      m_scratch = 8'h00; m_ctrl = 8'h02; m_hi = 8'h03; m_lo = 8'hE8; m_commit = 16'd1000;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = 8'(a); reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic check_outputs(input string req);
      chk(req, int_mode, m_ctrl[4]);
      chk(req, int_en, m_ctrl[3]);
      chk(req, weight, m_ctrl[2:1]);
      chk(req, pwrdn, m_ctrl[0]);
      chk(req, period, clampv(m_commit));
   endtask

   task automatic sweep(input string req);
      logic [7:0] v;
      for (int a = 0; a < 256; a++) begin
         rd(a, v);
         chk(req, v, exp_rd(a));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      int pvals [12];
      model_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_outputs("R1");
      chk("R1", {p_sys, p_hist, p_mm, p_int}, 0);
      chk("R1", reg_rdata, 0);
      // R2 R3 R11 R12 sweep at defaults
      sweep("R2_R3_R11_R12 reset sweep");
      // R2 hold: no strobe, rdata stays
      rd(0, v);
      repeat (4) @(negedge clk);
      chk("R2 hold", reg_rdata, 8'h31);

      // write 0xFF everywhere except the command register
      for (int a = 0; a < 256; a++) if (a != 9) wr(a, 8'hFF);
      m_scratch = 8'hFF; m_ctrl = 8'h1F; m_hi = 8'hFF; m_lo = 8'hFF; m_commit = 16'hFFFF;
      check_outputs("R5_R8 after all-ones");
      sweep("R3_R5_R12 all-ones sweep");

      // R6 power-down sticky
      wr(6, 8'h00);
      m_ctrl = 8'h01;
      check_outputs("R6 sticky");
      rd(6, v); chk("R6", v, 8'h01);
      wr(6, 8'hF4);
      m_ctrl = 8'h15;
      check_outputs("R5 fields");
      rd(6, v); chk("R5 reserved", v, 8'h15);

      // R9 command pulses, one bit at a time
      for (int b = 0; b < 3; b++) begin
         @(negedge clk);
         reg_addr = 8'h09; reg_wdata = 8'(1 << b); reg_wr = 1'b1;
         @(negedge clk);
         reg_wr = 1'b0;
         chk("R9 pulse", {p_sys, p_hist, p_mm, p_int}, 1 << b);
         @(negedge clk);
         chk("R9 one cycle", {p_sys, p_hist, p_mm, p_int}, 0);
      end
      check_outputs("R9 no side effect");
      // reserved bits only
      @(negedge clk);
      reg_addr = 8'h09; reg_wdata = 8'hF0; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R9 reserved", {p_sys, p_hist, p_mm, p_int}, 0);
      check_outputs("R9 reserved no effect");
      rd(9, v); chk("R9 reads zero", v, 0);

      // R10 system reset
      @(negedge clk);
      reg_addr = 8'h09; reg_wdata = 8'h08; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R9_R10 sys pulse", {p_sys, p_hist, p_mm, p_int}, 8);
      model_defaults();
      check_outputs("R10 restore");
      @(negedge clk);
      chk("R9 sys one cycle", p_sys, 0);
      sweep("R10 post-reset sweep");

      // R7 R8 period staging and clamping
      pvals = '{0, 9, 10, 11, 125, 1000, 9999, 10000, 10001, 65535, 256, 4660};
      foreach (pvals[i]) begin
         wr(7, pvals[i] >> 8);
         m_hi = 8'(pvals[i] >> 8);
         chk("R7 hi only staged", period, clampv(m_commit));
         rd(7, v); chk("R7 hi readback", v, m_hi);
         wr(8, pvals[i] & 8'hFF);
         m_lo = 8'(pvals[i]); m_commit = 16'(pvals[i]);
         chk("R7_R8 committed", period, clampv(m_commit));
         rd(8, v); chk("R7 lo readback", v, m_lo);
      end
      // low write alone reuses held high byte
      wr(8, 8'h05);
      m_lo = 8'h05; m_commit = {m_hi, m_lo};
      chk("R7 lo alone", period, clampv(m_commit));

      // R4 scratch all values
      for (int d = 0; d < 256; d++) begin
         wr(5, d);
         rd(5, v);
         chk("R4 scratch", v, d);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule